// File: doc/BRIEF.md
# Timer with Fast Flag Clear

A 16-bit timer counter with eight capture/compare channels, reached through a byte-wide register bus. A shared clock divider paces the counter. It runs either in a legacy mode, which divides by a power of two chosen by a 3-bit field, or in a precision mode, which divides by an 8-bit value plus one. The choice between the two modes can be made once after reset.

Each channel is either an input capture, which latches the counter on a rising input edge, or an output compare, which raises its flag and drives a programmed level on its pin when the counter reaches the channel value. The counter raises an overflow flag when it wraps.

Flags normally clear by writing 1 to them. An optional fast-clear mode lets ordinary data accesses clear flags instead. Reading a capture register or writing a compare register clears that channel's flag. Any access to the counter bytes clears the overflow flag.

Output-compare pins can toggle on every counter wrap. A fixed precedence decides each pin's action when several actions fall on the same clock edge. A channel-7 match can override any masked pin.

Register map (byte addresses):

| Address | Contents |
|---|---|
| 0x00 | Control: bit0 run, bit1 fast clear, bit2 precision select |
| 0x01 | Legacy divide field, bits [2:0] |
| 0x02 | Precision divide value |
| 0x03 | Channel mode: 1 = output compare, 0 = input capture |
| 0x04 | Toggle-on-wrap enables |
| 0x05 | Force strobe (write only) |
| 0x06 | Override mask |
| 0x07 | Override levels |
| 0x08 | Compare action levels |
| 0x09 | Channel flags |
| 0x0A | Overflow flag, bit0 |
| 0x0C / 0x0D | Counter high / low byte |
| 0x10+2n / 0x11+2n | Channel n value, high / low byte |

Top module: `fastclr_timer`

## Requirements
- R1: After reset the control register, the channel flags, the overflow flag, the counter and all pins read 0.
- R2: With precision select 0, the counter advances once every 2^N clocks, where N is control field 0x01[2:0], while run (0x00 bit0) is 1.
- R3: With precision select (0x00 bit2) at 1, the counter advances once every P+1 clocks, where P is the full byte at 0x02; the legacy field is then unused.
- R4: The first write to 0x00 after reset fixes bit2; later writes leave bit2 unchanged while bits 0 and 1 still follow the write.
- R5: The counter sets the overflow flag (0x0A bit0) on the clock edge where it steps from 0xFFFF to 0x0000.
- R6: An output-compare channel sets its flag (0x09 bit n) and drives its pin to level 0x08 bit n on the edge where the counter steps onto the channel value. An input-capture channel latches the counter and sets its flag on a rising edge of its input.
- R7: With fast clear (0x00 bit1) at 0, a flag clears only when 1 is written to its bit in 0x09 or 0x0A. Writing 0 has no effect, and data-register accesses leave flags set.
- R8: With fast clear at 1, reading either byte of an input-capture channel register, or writing either byte of an output-compare channel register, clears that channel's flag.
- R9: With fast clear at 1, any read or write of 0x0C or 0x0D clears the overflow flag.
- R10: If a flag is set and cleared on the same edge, it ends set.
- R11: A channel whose bit in 0x04 is 1 toggles its pin on each counter wrap, but only in output-compare mode; input-capture pins never change.
- R12: Pin action precedence, highest first: channel-7 match override on pins masked in 0x06 (level from 0x07), then toggle on wrap, then force (0x05) or own compare match (level from 0x08).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| bus_addr | input | 6 | Register byte address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cap_in | input | 8 | Capture inputs, one per channel |
| oc_pin | output | 8 | Output-compare pins, one per channel |

## Verification
Read data is combinational, so the bench samples it 1 ns after raising the read strobe. The flag clear that a read or write causes appears after the next rising edge. Counter steps, compare flags, pin changes, captures and the overflow flag land on the same edge that makes the counter step, so the bench stops the counter with a write and counts the exact edges that run was active. Division ratios follow from that count. Precedence cases line up the wrap edge with a force write or a channel-7 match on the same edge, and the bench reads the result one cycle later at a falling edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CH_N   = 8;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int LEG_W  = 3;
  localparam int PREC_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] A_LEG   = 6'h01;
  localparam logic [ADDR_W-1:0] A_PREC  = 6'h02;
  localparam logic [ADDR_W-1:0] A_MODE  = 6'h03;
  localparam logic [ADDR_W-1:0] A_TOV   = 6'h04;
  localparam logic [ADDR_W-1:0] A_FORCE = 6'h05;
  localparam logic [ADDR_W-1:0] A_OMASK = 6'h06;
  localparam logic [ADDR_W-1:0] A_OLVL  = 6'h07;
  localparam logic [ADDR_W-1:0] A_ACT   = 6'h08;
  localparam logic [ADDR_W-1:0] A_CHFLG = 6'h09;
  localparam logic [ADDR_W-1:0] A_OVF   = 6'h0A;
  localparam logic [ADDR_W-1:0] A_CNTH  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_CNTL  = 6'h0D;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int LEG_W  = 3,
  parameter int PREC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              prec_sel,
  input  logic [LEG_W-1:0]  leg_div,
  input  logic [PREC_W-1:0] prec_div,
  output logic              tick
);
  localparam int LEG_MAX_W = (2 ** LEG_W) - 1;
  localparam int DIV_W     = (PREC_W > LEG_MAX_W) ? PREC_W : LEG_MAX_W;

  logic [DIV_W-1:0] div_q, div_d, limit;

  always_comb begin
    if (prec_sel) limit = DIV_W'(prec_div);
    else          limit = (DIV_W'(1) << leg_div) - DIV_W'(1);
    tick  = run && (div_q == limit);
    div_d = (!run || tick) ? '0 : div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld_hi,
  input  logic             ld_lo,
  input  logic [7:0]       ld_byte,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_inc,
  output logic             step,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    step    = tick && !(ld_hi || ld_lo);
    wrap    = step && (cnt_q == {CNT_W{1'b1}});
    cnt_d   = cnt_q;
    if (ld_hi) cnt_d[CNT_W-1 -: 8] = ld_byte;
    if (ld_lo) cnt_d[7:0]          = ld_byte;
    if (step)  cnt_d               = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_oc,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_inc,
  input  logic             cap_in,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [7:0]       wbyte,
  input  logic             rd_any,
  input  logic             fast_clr,
  input  logic             w1c,
  input  logic             force_in,
  input  logic             tov_en,
  input  logic             wrap,
  input  logic             ovr_hit,
  input  logic             ovr_lvl,
  input  logic             act_lvl,
  output logic [CNT_W-1:0] val_q,
  output logic             flag_q,
  output logic             pin_q,
  output logic             hit,
  output logic             set_evt
);
  logic [CNT_W-1:0] val_d;
  logic flag_d, pin_d, cap_prev_q, cap_evt, fast_hit;

  always_comb begin
    hit      = is_oc && step && (cnt_inc == val_q);
    cap_evt  = !is_oc && cap_in && !cap_prev_q;
    set_evt  = hit || cap_evt;
    fast_hit = fast_clr && (is_oc ? (wr_hi || wr_lo) : rd_any);

    val_d = val_q;
    if (wr_hi)   val_d[CNT_W-1 -: 8] = wbyte;
    if (wr_lo)   val_d[7:0]          = wbyte;
    if (cap_evt) val_d               = cnt_q;

    if (set_evt)               flag_d = 1'b1;
    else if (w1c || fast_hit)  flag_d = 1'b0;
    else                       flag_d = flag_q;

    pin_d = pin_q;
    if (is_oc) begin
      if (ovr_hit)                pin_d = ovr_lvl;
      else if (wrap && tov_en)    pin_d = ~pin_q;
      else if (force_in || hit)   pin_d = act_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q      <= '0;
      flag_q     <= 1'b0;
      pin_q      <= 1'b0;
      cap_prev_q <= 1'b0;
    end else begin
      val_q      <= val_d;
      flag_q     <= flag_d;
      pin_q      <= pin_d;
      cap_prev_q <= cap_in;
    end
  end
endmodule

// File: rtl/fastclr_timer.sv
module fastclr_timer
  import tmr_pkg::*;
(
  input  logic [0:0]        clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CH_N-1:0]   cap_in,
  output logic [CH_N-1:0]   oc_pin
);
  localparam int CH_IDX_W = $clog2(CH_N);
  localparam int REG_HI   = ADDR_W - 1;
  localparam int REG_LO   = CH_IDX_W + 1;

  // control state
  logic run_q, run_d, fast_q, fast_d, prec_q, prec_d, lock_q, lock_d;
  logic [LEG_W-1:0]  leg_q, leg_d;
  logic [PREC_W-1:0] pdiv_q, pdiv_d;
  logic [CH_N-1:0]   mode_q, mode_d, tov_q, tov_d;
  logic [CH_N-1:0]   omask_q, omask_d, olvl_q, olvl_d, act_q, act_d;
  logic ovf_q, ovf_d;

  // decode
  logic wr_ctrl, wr_ovf, cnt_acc, ovf_clr, ch_region, tick, step, wrap;
  logic [CH_IDX_W-1:0] ch_idx;
  logic [CH_N-1:0] force_v, w1c_v, ch_flag, ch_hit, ch_set, ovr_hit;
  logic [CH_N-1:0] wr_hi_v, wr_lo_v, rd_v;
  logic [CH_N-1:0][CNT_W-1:0] ch_val;
  logic [CNT_W-1:0] cnt_q, cnt_inc;

  assign ch_region = (bus_addr[REG_HI:REG_LO] == (REG_HI - REG_LO + 1)'(1));
  assign ch_idx    = bus_addr[CH_IDX_W:1];
  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign wr_ovf    = bus_wr && (bus_addr == A_OVF);
  assign cnt_acc   = (bus_wr || bus_rd) && ((bus_addr == A_CNTH) || (bus_addr == A_CNTL));
  assign ovf_clr   = (wr_ovf && bus_wdata[0]) || (fast_q && cnt_acc);
  assign force_v   = (bus_wr && (bus_addr == A_FORCE)) ? bus_wdata : '0;
  assign w1c_v     = (bus_wr && (bus_addr == A_CHFLG)) ? bus_wdata : '0;

  always_comb begin
    run_d = run_q; fast_d = fast_q; prec_d = prec_q; lock_d = lock_q;
    leg_d = leg_q; pdiv_d = pdiv_q; mode_d = mode_q; tov_d = tov_q;
    omask_d = omask_q; olvl_d = olvl_q; act_d = act_q;
    if (wr_ctrl) begin
      run_d  = bus_wdata[0];
      fast_d = bus_wdata[1];
      lock_d = 1'b1;
      if (!lock_q) prec_d = bus_wdata[2];
    end
    if (bus_wr) begin
      unique case (bus_addr)
        A_LEG:   leg_d   = bus_wdata[LEG_W-1:0];
        A_PREC:  pdiv_d  = bus_wdata;
        A_MODE:  mode_d  = bus_wdata;
        A_TOV:   tov_d   = bus_wdata;
        A_OMASK: omask_d = bus_wdata;
        A_OLVL:  olvl_d  = bus_wdata;
        A_ACT:   act_d   = bus_wdata;
        default: ;
      endcase
    end
    if (wrap)         ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
    else              ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; fast_q <= 1'b0; prec_q <= 1'b0; lock_q <= 1'b0;
      leg_q <= '0; pdiv_q <= '0; mode_q <= '0; tov_q <= '0;
      omask_q <= '0; olvl_q <= '0; act_q <= '0; ovf_q <= 1'b0;
    end else begin
      run_q <= run_d; fast_q <= fast_d; prec_q <= prec_d; lock_q <= lock_d;
      leg_q <= leg_d; pdiv_q <= pdiv_d; mode_q <= mode_d; tov_q <= tov_d;
      omask_q <= omask_d; olvl_q <= olvl_d; act_q <= act_d; ovf_q <= ovf_d;
    end
  end

  tmr_prescaler #(.LEG_W(LEG_W), .PREC_W(PREC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .prec_sel(prec_q),
    .leg_div(leg_q), .prec_div(pdiv_q), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ld_hi(bus_wr && (bus_addr == A_CNTH)), .ld_lo(bus_wr && (bus_addr == A_CNTL)),
    .ld_byte(bus_wdata), .cnt_q(cnt_q), .cnt_inc(cnt_inc), .step(step), .wrap(wrap)
  );

  for (genvar n = 0; n < CH_N; n++) begin : g_ch
    assign wr_hi_v[n] = bus_wr && ch_region && (ch_idx == CH_IDX_W'(n)) && !bus_addr[0];
    assign wr_lo_v[n] = bus_wr && ch_region && (ch_idx == CH_IDX_W'(n)) &&  bus_addr[0];
    assign rd_v[n]    = bus_rd && ch_region && (ch_idx == CH_IDX_W'(n));
    assign ovr_hit[n] = omask_q[n] && ch_hit[CH_N-1];

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .is_oc(mode_q[n]), .step(step),
      .cnt_q(cnt_q), .cnt_inc(cnt_inc), .cap_in(cap_in[n]),
      .wr_hi(wr_hi_v[n]), .wr_lo(wr_lo_v[n]), .wbyte(bus_wdata), .rd_any(rd_v[n]),
      .fast_clr(fast_q), .w1c(w1c_v[n]), .force_in(force_v[n]), .tov_en(tov_q[n]),
      .wrap(wrap), .ovr_hit(ovr_hit[n]), .ovr_lvl(olvl_q[n]), .act_lvl(act_q[n]),
      .val_q(ch_val[n]), .flag_q(ch_flag[n]), .pin_q(oc_pin[n]),
      .hit(ch_hit[n]), .set_evt(ch_set[n])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (ch_region) begin
      bus_rdata = bus_addr[0] ? ch_val[ch_idx][7:0] : ch_val[ch_idx][CNT_W-1 -: 8];
    end else begin
      unique case (bus_addr)
        A_CTRL:  bus_rdata = {5'd0, prec_q, fast_q, run_q};
        A_LEG:   bus_rdata = DATA_W'(leg_q);
        A_PREC:  bus_rdata = pdiv_q;
        A_MODE:  bus_rdata = mode_q;
        A_TOV:   bus_rdata = tov_q;
        A_OMASK: bus_rdata = omask_q;
        A_OLVL:  bus_rdata = olvl_q;
        A_ACT:   bus_rdata = act_q;
        A_CHFLG: bus_rdata = ch_flag;
        A_OVF:   bus_rdata = {7'd0, ovf_q};
        A_CNTH:  bus_rdata = cnt_q[CNT_W-1 -: 8];
        A_CNTL:  bus_rdata = cnt_q[7:0];
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              fast_q,
  input logic              prec_q,
  input logic              lock_q,
  input logic              wrap,
  input logic              ovf_q,
  input logic [CH_N-1:0]   mode_q,
  input logic [CH_N-1:0]   tov_q,
  input logic [CH_N-1:0]   olvl_q,
  input logic [CH_N-1:0]   ovr_hit,
  input logic [CH_N-1:0]   ch_set,
  input logic [CH_N-1:0]   ch_flag,
  input logic [CH_N-1:0]   oc_pin
);
  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> ovf_q); // R5
  AST_NORMAL_KEEPS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_q && ovf_q && !(bus_wr && bus_addr == A_OVF && bus_wdata[0])) |=> ovf_q); // R7
  AST_PREC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) lock_q |=> $stable(prec_q)); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) lock_q |=> lock_q); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_set != '0) |=> ((ch_flag & $past(ch_set)) == $past(ch_set))); // R10

  for (genvar n = 0; n < CH_N; n++) begin : g_pin
    AST_IC_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q[n] |=> $stable(oc_pin[n])); // R11
    AST_TOV_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[n] && tov_q[n] && wrap && !ovr_hit[n]) |=> (oc_pin[n] != $past(oc_pin[n]))); // R12
    AST_OVR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[n] && ovr_hit[n]) |=> (oc_pin[n] == $past(olvl_q[n]))); // R12
  end
endmodule

bind fastclr_timer tmr_chk i_tmr_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .fast_q(fast_q), .prec_q(prec_q), .lock_q(lock_q), .wrap(wrap), .ovf_q(ovf_q),
  .mode_q(mode_q), .tov_q(tov_q), .olvl_q(olvl_q), .ovr_hit(ovr_hit),
  .ch_set(ch_set), .ch_flag(ch_flag), .oc_pin(oc_pin)
);

// File: tb/test_fastclr_timer.sv
`timescale 1ns/1ps
module test_fastclr_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] cap_in = '0;
  logic [7:0] oc_pin;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  fastclr_timer i_fastclr_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .oc_pin(oc_pin)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_rd(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; cap_in = '0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  // counter FFFE -> FFFF -> 0000 with run on for exactly two edges
  task automatic wrap_once(input logic [7:0] ctrl_base);
    wr(6'h0C, 8'hFF); wr(6'h0D, 8'hFE);
    wr(6'h00, ctrl_base | 8'h01);
    idle(1);
    wr(6'h00, ctrl_base);
  endtask

  task automatic t_reset();
    do_reset();
    chk_rd("R1 ctrl", 6'h00, 8'h00);
    chk_rd("R1 chflags", 6'h09, 8'h00);
    chk_rd("R1 ovf", 6'h0A, 8'h00);
    chk_rd("R1 cnt hi", 6'h0C, 8'h00);
    chk_rd("R1 cnt lo", 6'h0D, 8'h00);
    check("R1 pins", oc_pin, 8'h00);
  endtask

  task automatic t_legacy();
    do_reset();
    wr(6'h01, 8'h02);              // divide by 4
    wr(6'h00, 8'h01); idle(12); wr(6'h00, 8'h00);  // 13 run edges
    chk_rd("R2 div4 lo", 6'h0D, 8'h03);
    chk_rd("R2 div4 hi", 6'h0C, 8'h00);
    wr(6'h01, 8'h00);              // divide by 1
    wr(6'h00, 8'h01); idle(4); wr(6'h00, 8'h00);   // 5 run edges
    chk_rd("R2 div1 lo", 6'h0D, 8'h08);
  endtask

  task automatic t_precision();
    do_reset();
    wr(6'h02, 8'h02);              // divide by 3
    wr(6'h01, 8'h05);              // legacy field unused
    wr(6'h00, 8'h04);              // precision, first write
    wr(6'h00, 8'h05); idle(10); wr(6'h00, 8'h04);  // 11 run edges
    chk_rd("R3 div3 lo", 6'h0D, 8'h03);
    wr(6'h00, 8'h02);
    chk_rd("R4 bit2 kept at 1", 6'h00, 8'h06);
    do_reset();
    wr(6'h00, 8'h00);
    wr(6'h00, 8'h04);
    chk_rd("R4 bit2 kept at 0", 6'h00, 8'h00);
  endtask

  task automatic t_ovf_normal();
    do_reset();
    wrap_once(8'h00);
    chk_rd("R5 ovf set", 6'h0A, 8'h01);
    chk_rd("R5 cnt wrapped", 6'h0D, 8'h00);
    chk_rd("R7 ovf after cnt read", 6'h0A, 8'h01);
    wr(6'h0A, 8'h00);
    chk_rd("R7 write 0", 6'h0A, 8'h01);
    wr(6'h0A, 8'h01);
    chk_rd("R7 write 1", 6'h0A, 8'h00);
  endtask

  task automatic t_ovf_fast();
    logic [7:0] d;
    do_reset();
    wrap_once(8'h02);
    chk_rd("R9 ovf set", 6'h0A, 8'h01);
    rd(6'h0D, d);
    chk_rd("R9 read clears", 6'h0A, 8'h00);
    wrap_once(8'h02);
    chk_rd("R9 ovf set again", 6'h0A, 8'h01);
    wr(6'h0C, 8'h12);
    chk_rd("R9 write clears", 6'h0A, 8'h00);
  endtask

  task automatic t_channels();
    logic [7:0] d;
    do_reset();
    wr(6'h03, 8'h01);              // ch0 compare, others capture
    wr(6'h08, 8'h01);
    wr(6'h10, 8'h00); wr(6'h11, 8'h05);
    wr(6'h00, 8'h01); idle(5); wr(6'h00, 8'h00);   // counter ends at 6
    chk_rd("R6 compare flag", 6'h09, 8'h01);
    check("R6 compare pin", oc_pin, 8'h01);
    cap_in[1] = 1'b1; idle(1); cap_in[1] = 1'b0;
    chk_rd("R6 capture hi", 6'h12, 8'h00);
    chk_rd("R6 capture lo", 6'h13, 8'h06);
    chk_rd("R7 reads keep flags", 6'h09, 8'h03);
    wr(6'h11, 8'h30);
    chk_rd("R7 compare write keeps flag", 6'h09, 8'h03);
    wr(6'h09, 8'h00);
    chk_rd("R7 w1c zero", 6'h09, 8'h03);
    wr(6'h09, 8'h02);
    chk_rd("R7 w1c one", 6'h09, 8'h01);
    wr(6'h00, 8'h02);              // fast clear on
    cap_in[1] = 1'b1; idle(1); cap_in[1] = 1'b0;
    chk_rd("R8 capture flag", 6'h09, 8'h03);
    rd(6'h13, d);
    chk_rd("R8 capture read clears", 6'h09, 8'h01);
    wr(6'h11, 8'h20);
    chk_rd("R8 compare write clears", 6'h09, 8'h00);
    cap_in[1] = 1'b1;
    rd(6'h13, d);
    cap_in[1] = 1'b0;
    chk_rd("R10 set beats clear", 6'h09, 8'h02);
  endtask

  task automatic t_tov();
    do_reset();
    wr(6'h03, 8'h81);              // ch0 and ch7 compare, ch1 capture
    wr(6'h04, 8'h03);
    wr(6'h08, 8'h80);
    wr(6'h10, 8'h12); wr(6'h11, 8'h34);
    wrap_once(8'h00);
    check("R11 toggle on wrap", oc_pin & 8'h03, 8'h01);
    check("R6 ch7 compare at zero", oc_pin & 8'h80, 8'h80);
    wrap_once(8'h00);
    check("R11 toggle back, capture pin still", oc_pin & 8'h03, 8'h00);
    wr(6'h0C, 8'hFF); wr(6'h0D, 8'hFE);
    wr(6'h00, 8'h01); idle(1); wr(6'h05, 8'h01); wr(6'h00, 8'h00);
    check("R12 toggle beats force", oc_pin & 8'h01, 8'h01);
    wr(6'h05, 8'h01);
    check("R12 force alone", oc_pin & 8'h01, 8'h00);
    wr(6'h06, 8'h01); wr(6'h07, 8'h00);
    wr(6'h0A, 8'h01); wr(6'h09, 8'hFF);
    wrap_once(8'h00);
    chk_rd("R12 wrap occurred", 6'h0A, 8'h01);
    chk_rd("R12 ch7 matched", 6'h09, 8'h80);
    check("R12 override beats toggle", oc_pin & 8'h01, 8'h00);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_legacy();
    t_precision();
    t_ovf_normal();
    t_ovf_fast();
    t_channels();
    t_tov();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule